// File: doc/BRIEF.md
# PCIe Error Interrupt Status Registers

This block collects six single-cycle error event pulses from a PCIe controller and holds them in a sticky raw status register. Software sees two views of that state. The raw view shows every event that has been seen. The enabled view shows only the events whose enable bit is set. The enable mask has two write ports: one turns bits on and the other turns bits off, so software never has to read, modify and write the mask.

Two outputs report the state. `irq_out` is a level interrupt that stays high while any enabled status bit is set. `fatal_out` is a level flag that stays high while either of the two fatal event kinds is held in raw status, whatever the mask holds. Software reaches the registers through a word-addressed strobe interface. The read data is registered and appears one cycle after the read strobe. A handler reads the enabled view and writes the same value back to clear it.

Top module: `pcie_err_status`

## Requirements
- R1: After reset, raw status and the enable mask are zero, `irq_out` and `fatal_out` are low, and `reg_rdata` is zero.
- R2: An event pulse on bit i sets raw status bit i at the next clock edge, whether or not the bit is enabled. Bit meanings: 0 system error summary, 1 fatal, 2 non-fatal, 3 correctable, 4 interconnect tag lookup fatal, 5 ECRC error. Raw status reads at offset 0x1C0.
- R3: A write to offset 0x1C8 sets the mask bits written as 1. A write to offset 0x1CC clears the mask bits written as 1. Bits written as 0 leave the mask unchanged. A read of either offset returns the mask.
- R4: A write to 0x1C0 or to 0x1C4 clears each raw status bit written as 1 and leaves the other bits as they are. Clearing does not depend on the mask.
- R5: If an event on bit i arrives in the same cycle as a write that clears bit i, the bit stays set.
- R6: A read at offset 0x1C4 returns raw status AND mask. `irq_out` is high exactly when that value is nonzero.
- R7: `fatal_out` is high exactly when raw bit 1 or raw bit 4 is set, whatever the mask holds.
- R8: Read bits 31 to 6 are always zero, and write bits 31 to 6 have no effect. An address that matches no register reads as zero, and a write to it changes nothing.
- R9: `reg_rdata` is loaded at the clock edge on which `reg_rd` is sampled and holds until the next read. When a read and a write to the same address fall in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 6 | Error event pulses, one bit per error kind |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 12 | Byte offset of the word accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Error interrupt, OR of the enabled status |
| fatal_out | output | 1 | Fatal error flag, OR of raw bits 1 and 4 |

## Verification
The bench builds the block with its default parameters: six event bits and the default offsets. With only six bits, every one of the 64 mask values can be crossed with every one of the 64 event patterns. For each pair the bench checks the raw view, the enabled view, the interrupt, the fatal flag and a partial write-1-to-clear. The remaining directed cases cover a clear that collides with an event, unmapped addresses, writes to the upper data bits, and a read and a write that fall in the same cycle.

// File: rtl/pcie_err_pkg.sv
package pcie_err_pkg;

    // Which register a bus address selects
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RAW,
        SEL_ENA,
        SEL_SET,
        SEL_CLR
    } reg_sel_e;

endpackage

// File: rtl/err_addr_decode.sv
module err_addr_decode #(
    parameter int ADDR_W  = 12,
    parameter int OFS_RAW = 'h1C0,
    parameter int OFS_ENA = 'h1C4,
    parameter int OFS_SET = 'h1C8,
    parameter int OFS_CLR = 'h1CC
) (
    input  logic [ADDR_W-1:0]      addr,
    output pcie_err_pkg::reg_sel_e sel
);
    import pcie_err_pkg::*;

    always_comb begin
        if (addr == ADDR_W'(OFS_RAW))      sel = SEL_RAW;
        else if (addr == ADDR_W'(OFS_ENA)) sel = SEL_ENA;
        else if (addr == ADDR_W'(OFS_SET)) sel = SEL_SET;
        else if (addr == ADDR_W'(OFS_CLR)) sel = SEL_CLR;
        else                               sel = SEL_NONE;
    end

endmodule

// File: rtl/err_raw_status.sv
module err_raw_status #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] raw
);
    typedef struct packed {
        logic [N-1:0] bits;
    } raw_state_t;

    raw_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr_en) begin
            state_d.bits = state_d.bits & ~clr_bits;
        end
        // A new event is applied after the clear, so it wins a collision
        state_d.bits = state_d.bits | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign raw = state_q.bits;

endmodule

// File: rtl/err_enable_mask.sv
module err_enable_mask #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [N-1:0] bits,
    output logic [N-1:0] mask
);
    typedef struct packed {
        logic [N-1:0] mask;
    } mask_state_t;

    mask_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (set_en)      state_d.mask = state_q.mask | bits;
        else if (clr_en) state_d.mask = state_q.mask & ~bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign mask = state_q.mask;

endmodule

// File: rtl/err_readback.sv
module err_readback #(
    parameter int N      = 6,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd,
    input  pcie_err_pkg::reg_sel_e sel,
    input  logic [N-1:0]           raw,
    input  logic [N-1:0]           mask,
    output logic [DATA_W-1:0]      rdata
);
    import pcie_err_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t    state_d, state_q;
    logic [N-1:0] word;

    always_comb begin
        case (sel)
            SEL_RAW:          word = raw;
            SEL_ENA:          word = raw & mask;
            SEL_SET, SEL_CLR: word = mask;
            default:          word = '0;
        endcase
        state_d = state_q;
        if (rd) state_d.data = DATA_W'(word);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rdata = state_q.data;

endmodule

// File: rtl/pcie_err_status.sv
module pcie_err_status #(
    parameter int             N          = 6,
    parameter int             ADDR_W     = 12,
    parameter int             DATA_W     = 32,
    parameter int             OFS_RAW    = 'h1C0,
    parameter int             OFS_ENA    = 'h1C4,
    parameter int             OFS_SET    = 'h1C8,
    parameter int             OFS_CLR    = 'h1CC,
    parameter logic [N-1:0]   FATAL_MASK = 6'b01_0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      evt_pulse,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out,
    output logic              fatal_out
);
    import pcie_err_pkg::*;

    reg_sel_e     sel;
    logic [N-1:0] raw_status;
    logic [N-1:0] enable_mask;
    logic [N-1:0] wbits;
    logic         wdata_unused;

    assign wbits        = reg_wdata[N-1:0];
    assign wdata_unused = ^reg_wdata[DATA_W-1:N];

    err_addr_decode #(
        .ADDR_W (ADDR_W),
        .OFS_RAW(OFS_RAW),
        .OFS_ENA(OFS_ENA),
        .OFS_SET(OFS_SET),
        .OFS_CLR(OFS_CLR)
    ) u_dec (
        .addr(reg_addr),
        .sel (sel)
    );

    err_raw_status #(.N(N)) u_raw (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_pulse),
        .clr_en  (reg_wr && (sel == SEL_RAW || sel == SEL_ENA)),
        .clr_bits(wbits),
        .raw     (raw_status)
    );

    err_enable_mask #(.N(N)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .set_en(reg_wr && sel == SEL_SET),
        .clr_en(reg_wr && sel == SEL_CLR),
        .bits  (wbits),
        .mask  (enable_mask)
    );

    err_readback #(.N(N), .DATA_W(DATA_W)) u_rd (
        .clk  (clk),
        .rst_n(rst_n),
        .rd   (reg_rd),
        .sel  (sel),
        .raw  (raw_status),
        .mask (enable_mask),
        .rdata(reg_rdata)
    );

    assign irq_out   = |(raw_status & enable_mask);
    assign fatal_out = |(raw_status & FATAL_MASK);

endmodule

// File: rtl/pcie_err_status_chk.sv
module pcie_err_status_chk #(
    parameter int           N          = 6,
    parameter int           ADDR_W     = 12,
    parameter int           DATA_W     = 32,
    parameter int           OFS_RAW    = 'h1C0,
    parameter int           OFS_ENA    = 'h1C4,
    parameter int           OFS_SET    = 'h1C8,
    parameter logic [N-1:0] FATAL_MASK = 6'b01_0010
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      evt_pulse,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_out,
    input logic              fatal_out,
    input logic [N-1:0]      raw_status,
    input logic [N-1:0]      enable_mask
);
    logic clr_wr;
    assign clr_wr = reg_wr && (reg_addr == ADDR_W'(OFS_RAW) || reg_addr == ADDR_W'(OFS_ENA));

    assert_evt_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((raw_status & $past(evt_pulse)) == $past(evt_pulse)));

    assert_raw_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((raw_status & $past(raw_status)) == $past(raw_status)));

    assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_SET)) |=>
        ((enable_mask & $past(reg_wdata[N-1:0])) == $past(reg_wdata[N-1:0])));

    assert_irq_needs_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (enable_mask != '0 && raw_status != '0));

    assert_fatal_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_pulse & FATAL_MASK) != '0) |=> fatal_out);

    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:N] == '0);

endmodule

bind pcie_err_status pcie_err_status_chk #(
    .N         (N),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .OFS_RAW   (OFS_RAW),
    .OFS_ENA   (OFS_ENA),
    .OFS_SET   (OFS_SET),
    .FATAL_MASK(FATAL_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_pulse  (evt_pulse),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq_out    (irq_out),
    .fatal_out  (fatal_out),
    .raw_status (raw_status),
    .enable_mask(enable_mask)
);

// File: tb/pcie_err_status_tb.sv
module pcie_err_status_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_RAW = 12'h1C0, A_ENA = 12'h1C4, A_SET = 12'h1C8,
                            A_CLR = 12'h1CC, A_BAD = 12'h1D0;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [5:0]  evt_pulse = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [11:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq_out, fatal_out;

    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcie_err_status u_dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .fatal_out(fatal_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0; d = reg_rdata;
    endtask

    task automatic pulse(input logic [5:0] e);
        @(negedge clk); evt_pulse = e;
        @(negedge clk); evt_pulse = 0;
    endtask

    initial begin
        logic [31:0] d;
        logic [5:0]  exp_raw;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", 32'(irq_out), 0);
        check("R1 fatal", 32'(fatal_out), 0);
        check("R1 rdata", reg_rdata, 0);
        rd(A_RAW, d); check("R1 raw", d, 0);
        rd(A_SET, d); check("R1 mask", d, 0);

        // Sweep every mask against every event pattern: R2 R3 R4 R6 R7
        for (int m = 0; m < 64; m++) begin
            wr(A_CLR, 32'h3F);
            wr(A_SET, 32'(m));
            rd(A_CLR, d); check("R3 mask", d, 32'(m));
            for (int e = 0; e < 64; e++) begin
                wr(A_RAW, 32'h3F);
                pulse(6'(e));
                check("R6 irq", 32'(irq_out), 32'((e & m) != 0));
                check("R7 fatal", 32'(fatal_out), 32'((e & 6'b01_0010) != 0));
                rd(A_RAW, d); check("R2 raw", d, 32'(e));
                rd(A_ENA, d); check("R6 enabled", d, 32'(e & m));
                wr(A_ENA, 32'(m));
                rd(A_RAW, d); check("R4 partial clear", d, 32'(e & ~m & 63));
            end
        end

        // R3 zero bits leave mask alone
        wr(A_CLR, 32'h3F); wr(A_SET, 32'h05); wr(A_SET, 32'h20); wr(A_CLR, 32'h01);
        rd(A_SET, d); check("R3 set/clear", d, 32'h24);

        // R5 collision: clear all while bits 0 and 2 arrive
        wr(A_RAW, 32'h3F); pulse(6'h3F);
        @(negedge clk); reg_wr = 1; reg_addr = A_RAW; reg_wdata = 32'h3F; evt_pulse = 6'h05;
        @(negedge clk); reg_wr = 0; evt_pulse = 0;
        rd(A_RAW, d); check("R5 collision", d, 32'h05);

        // R8 upper bits and unmapped address
        wr(A_SET, 32'hFFFF_FFC0);
        rd(A_SET, d); check("R8 mask upper write", d, 32'h24);
        wr(A_BAD, 32'hFFFF_FFFF);
        rd(A_RAW, d); check("R8 raw after bad write", d, 32'h05);
        rd(A_SET, d); check("R8 mask after bad write", d, 32'h24);
        rd(A_BAD, d); check("R8 unmapped read", d, 0);
        wr(A_RAW, 32'hFFFF_FFC0);
        rd(A_RAW, d); check("R8 raw upper write", d, 32'h05);

        // R9 read concurrent with write returns pre-write value
        @(negedge clk); reg_wr = 1; reg_rd = 1; reg_addr = A_RAW; reg_wdata = 32'h3F;
        @(negedge clk); reg_wr = 0; reg_rd = 0; d = reg_rdata;
        check("R9 read-before-write", d, 32'h05);
        repeat (2) @(negedge clk);
        check("R9 rdata held", reg_rdata, 32'h05);
        rd(A_RAW, d); check("R9 after write", d, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule